// File: doc/BRIEF.md
# Index-Port Watchdog Timer

This block is a system watchdog reached through a pair of byte-wide I/O ports: an index port at 0x2E and a data port at 0x2F. A host first writes 0x87 to the index port twice in a row to unlock configuration mode. It then selects logical device 7 through index register 0x07. Next it writes the reset-output enable (0xF0), the timeout count (0xF6) and the control register (0xF5). Finally it writes 0xAA to the index port to lock the block again.

Once enabled, the counter drops by one on every unit tick. A unit is `TICK_CYCLES` clock cycles, one second at the default setting. Firmware keeps the system alive by writing the enable bit again, or by writing a new count, before the counter reaches zero. When the counter does reach zero, the block sets a timeout flag. If the reset output is enabled, it also drives an active-low pulse of `RST_PULSE` cycles. After that the counter stays at zero until firmware reloads it.

The host interface is a plain strobe bus, with no back-pressure. A write takes effect at the clock edge where `io_wr` is high. Read data is combinational and valid while `io_rd` is high.

Top module: `idxport_wdt`

## Requirements
- R1: After reset the block is locked. The reset output `wdt_rst_n` is high, registers 0xF0 and 0xF5 read 0x00, and register 0xF6 reads 0x01.
- R2: Configuration opens only when 0x87 is written to the index port on two consecutive bus writes. Any other index value, or any data-port write, between the two returns the block to the locked state. While locked, a read of either port returns 0xFF.
- R3: While open, an index write of 0xAA locks the block. After that, data-port writes change no register, and reads of either port return 0xFF.
- R4: Index 0x07 holds the logical device number and reads back. Registers 0xF0, 0xF5 and 0xF6 respond only while the device number is 7. With any other device number, writes to them are ignored and reads return 0xFF.
- R5: Field positions are fixed. In 0xF0, bit 7 is the reset-output enable. In 0xF5, bit 5 is the watchdog enable and bit 6 is the timeout flag. 0xF6 is the whole count. Bits not listed read as 0. An unimplemented index reads 0xFF.
- R6: A write of 0x00 to 0xF6 is ignored, so the count keeps its previous value (range 1 to 255).
- R7: A 0xF5 write with bit 5 set enables the watchdog and loads the counter from 0xF6. With count N, the timeout occurs N×`TICK_CYCLES` cycles after that write. A repeat of the same write before then restarts the full period.
- R8: A nonzero 0xF6 write while the watchdog is enabled reloads the counter with the new value and restarts the period.
- R9: At timeout the flag is set. If 0xF0 bit 7 is 1, `wdt_rst_n` goes low on the same edge and stays low for exactly `RST_PULSE` cycles.
- R10: If 0xF0 bit 7 is 0 at timeout, only the flag is set. The counter stays at zero and produces no further timeout, even if the reset output is enabled later.
- R11: Writing 1 to bit 6 of 0xF5 clears the flag. Writing 0 there leaves the flag as it is.
- R12: Writing 0xF5 with bit 5 clear disables the watchdog and halts the countdown, so no timeout follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_wr | input | 1 | Bus write strobe |
| io_rd | input | 1 | Bus read strobe |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational while `io_rd` is high |
| wdt_rst_n | output | 1 | Active-low watchdog reset pulse |

## Verification
The bench targets several corner cases, and each names the fault it would catch:
- **Unlock sequence.** A 0x87 write, then a foreign write, then 0x87 must leave the block locked. A design that only counts 0x87 writes would open early.
- **Data-port write between the keys.** A data-port write between the two keys must also relock the block. A design that watches only the index port would open.
- **Expiry timing.** The bench checks the timeout to the exact cycle, the reset pulse width, and the restart caused by a kick and by a count rewrite. A prescaler that is not cleared on reload would fire one unit early.
- **Counter after a silent timeout.** After a timeout with the reset output disabled, the bench turns the output on and waits longer than a full wrap. A counter that wraps past zero would then produce a late, spurious pulse.
- **Ignored writes.** A zero count write, writes to the wrong logical device and writes after the exit key must all be shown to have no effect. The bench confirms this by reading the registers back.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DW = 8;

  localparam logic [DW-1:0] KEY_ENTER = 8'h87;
  localparam logic [DW-1:0] KEY_EXIT  = 8'hAA;
  localparam logic [DW-1:0] IX_LDN    = 8'h07;
  localparam logic [DW-1:0] IX_RSTCTL = 8'hF0;
  localparam logic [DW-1:0] IX_CTRL   = 8'hF5;
  localparam logic [DW-1:0] IX_COUNT  = 8'hF6;
  localparam logic [DW-1:0] WDT_DEV   = 8'h07;

  localparam int B_RSTEN = 7;
  localparam int B_FLAG  = 6;
  localparam int B_EN    = 5;

  typedef enum logic [1:0] {
    UL_LOCKED = 2'd0,
    UL_KEY1   = 2'd1,
    UL_OPEN   = 2'd2
  } unlock_st_e;

  typedef struct packed {
    logic rstctl;
    logic ctrl;
    logic count;
  } wdt_wsel_t;
endpackage

// File: rtl/cfgport_unlock.sv
module cfgport_unlock
  import wdt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_wr,
  input  logic          dat_wr,
  input  logic [DW-1:0] wdata,
  output logic          open,
  output logic [DW-1:0] index,
  output logic [DW-1:0] ldn
);
  unlock_st_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= UL_LOCKED;
      index <= '0;
      ldn   <= '0;
    end else if (idx_wr) begin
      unique case (st)
        UL_LOCKED: st <= (wdata == KEY_ENTER) ? UL_KEY1 : UL_LOCKED;
        UL_KEY1:   st <= (wdata == KEY_ENTER) ? UL_OPEN : UL_LOCKED;
        UL_OPEN: begin
          if (wdata == KEY_EXIT) begin
            st    <= UL_LOCKED;
            index <= '0;
          end else begin
            index <= wdata;
          end
        end
        default: st <= UL_LOCKED;
      endcase
    end else if (dat_wr) begin
      if (st == UL_KEY1) st <= UL_LOCKED;
      if (st == UL_OPEN && index == IX_LDN) ldn <= wdata;
    end
  end

  assign open = (st == UL_OPEN);

  AST_OPEN_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (open && !$past(open)) |-> ($past(idx_wr) && $past(wdata) == KEY_ENTER && $past(st) == UL_KEY1)); // R2
  AST_EXIT_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (open && idx_wr && wdata == KEY_EXIT) |=> !open); // R3
endmodule

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int TICK_CYCLES = 125_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pre <= '0;
    else if (restart || !run)  pre <= '0;
    else if (pre == LAST)      pre <= '0;
    else                       pre <= pre + 1'b1;
  end

  assign tick = run && !restart && (pre == LAST);

  generate
    if (TICK_CYCLES > 1) begin : g_spacing
      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R7
    end
  endgenerate
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int            RST_PULSE = 16,
  parameter logic [DW-1:0] DEF_COUNT = 8'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wdt_wsel_t     wsel,
  input  logic [DW-1:0] wdata,
  input  logic          tick,
  output logic          run,
  output logic          restart,
  output logic          rst_en,
  output logic          wdt_en,
  output logic          flag,
  output logic [DW-1:0] count_reg,
  output logic          wdt_rst_n
);
  localparam int PCW = $clog2(RST_PULSE + 1);

  logic [DW-1:0]  cnt;
  logic [PCW-1:0] pcnt;
  logic           count_ok;
  logic           expire;

  assign count_ok = (wdata != '0);
  assign restart  = (wsel.ctrl && wdata[B_EN]) || (wsel.count && wdt_en && count_ok);
  assign run      = wdt_en && (cnt != '0);
  assign expire   = tick && (cnt == DW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_en    <= 1'b0;
      wdt_en    <= 1'b0;
      count_reg <= DEF_COUNT;
    end else begin
      if (wsel.rstctl)            rst_en    <= wdata[B_RSTEN];
      if (wsel.ctrl)              wdt_en    <= wdata[B_EN];
      if (wsel.count && count_ok) count_reg <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (restart)                 cnt <= wsel.count ? wdata : count_reg;
    else if (tick && cnt != '0)       cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               flag <= 1'b0;
    else if (expire)                          flag <= 1'b1;
    else if (wsel.ctrl && wdata[B_FLAG])      flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pcnt <= '0;
    else if (expire && rst_en)  pcnt <= PCW'(RST_PULSE);
    else if (pcnt != '0)        pcnt <= pcnt - 1'b1;
  end

  assign wdt_rst_n = (pcnt == '0);

  AST_FLAG_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> (cnt == '0)); // R9
  AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_rst_n) |-> $past(rst_en)); // R10
  AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !restart) |=> (cnt == '0)); // R10
  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_en |-> !tick); // R12
endmodule

// File: rtl/idxport_wdt.sv
module idxport_wdt
  import wdt_pkg::*;
#(
  parameter int            AW          = 16,
  parameter logic [AW-1:0] IDX_PORT    = 16'h002E,
  parameter int            TICK_CYCLES = 125_000_000,
  parameter int            RST_PULSE   = 16,
  parameter logic [7:0]    DEF_COUNT   = 8'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [AW-1:0] io_addr,
  input  logic [7:0]    io_wdata,
  output logic [7:0]    io_rdata,
  output logic          wdt_rst_n
);
  localparam logic [AW-1:0] DAT_PORT = IDX_PORT + AW'(1);

  logic          idx_hit, dat_hit, open, dev_sel;
  logic [DW-1:0] index, ldn, count_reg;
  logic          run, restart, tick, rst_en, wdt_en, flag;
  wdt_wsel_t     wsel;

  assign idx_hit = (io_addr == IDX_PORT);
  assign dat_hit = (io_addr == DAT_PORT);

  cfgport_unlock u_unlock (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx_wr (io_wr && idx_hit),
    .dat_wr (io_wr && dat_hit),
    .wdata  (io_wdata),
    .open   (open),
    .index  (index),
    .ldn    (ldn)
  );

  assign dev_sel     = open && (ldn == WDT_DEV);
  assign wsel.rstctl = io_wr && dat_hit && dev_sel && (index == IX_RSTCTL);
  assign wsel.ctrl   = io_wr && dat_hit && dev_sel && (index == IX_CTRL);
  assign wsel.count  = io_wr && dat_hit && dev_sel && (index == IX_COUNT);

  wdt_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (restart),
    .tick    (tick)
  );

  wdt_core #(.RST_PULSE(RST_PULSE), .DEF_COUNT(DEF_COUNT)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .wsel      (wsel),
    .wdata     (io_wdata),
    .tick      (tick),
    .run       (run),
    .restart   (restart),
    .rst_en    (rst_en),
    .wdt_en    (wdt_en),
    .flag      (flag),
    .count_reg (count_reg),
    .wdt_rst_n (wdt_rst_n)
  );

  always_comb begin
    io_rdata = 8'hFF;
    if (io_rd && open) begin
      if (idx_hit) begin
        io_rdata = index;
      end else if (dat_hit) begin
        if (index == IX_LDN) io_rdata = ldn;
        else if (dev_sel) begin
          unique case (index)
            IX_RSTCTL: io_rdata = {rst_en, 7'b0};
            IX_CTRL:   io_rdata = {1'b0, flag, wdt_en, 5'b0};
            IX_COUNT:  io_rdata = count_reg;
            default:   io_rdata = 8'hFF;
          endcase
        end
      end
    end
  end

  AST_LOCKED_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && (idx_hit || dat_hit) && !open) |-> (io_rdata == 8'hFF)); // R2
  AST_OTHER_DEV_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && dat_hit && open && ldn != WDT_DEV && index != IX_LDN) |-> (io_rdata == 8'hFF)); // R4
endmodule

// File: tb/idxport_wdt_tb.sv
module idxport_wdt_tb;
  localparam int TICK = 10;
  localparam int PW   = 4;
  localparam logic [15:0] IXP = 16'h002E;
  localparam logic [15:0] DTP = 16'h002F;

  logic clk = 1'b0, rst_n = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0, io_rdata;
  logic        wdt_rst_n;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  idxport_wdt #(.TICK_CYCLES(TICK), .RST_PULSE(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .wdt_rst_n(wdt_rst_n));

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic io_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic io_read(logic [15:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    #2 d = io_rdata;
    @(negedge clk); io_rd = 1'b0;
  endtask

  task automatic wreg(logic [7:0] ix, logic [7:0] d);
    io_write(IXP, ix); io_write(DTP, d);
  endtask

  task automatic rreg(logic [7:0] ix, output logic [7:0] d);
    io_write(IXP, ix); io_read(DTP, d);
  endtask

  task automatic unlock();
    io_write(IXP, 8'h87); io_write(IXP, 8'h87);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 rst_n idle", {7'b0, wdt_rst_n}, 8'h01);
    io_read(DTP, v); check("R1 locked data read", v, 8'hFF);
    unlock(); wreg(8'h07, 8'h07);
    rreg(8'hF0, v); check("R1 F0 reset", v, 8'h00);
    rreg(8'hF5, v); check("R1 F5 reset", v, 8'h00);
    rreg(8'hF6, v); check("R1 F6 reset", v, 8'h01);
    io_write(IXP, 8'hAA);
  endtask

  task automatic t_unlock();
    logic [7:0] v;
    io_write(IXP, 8'h87); io_write(IXP, 8'h55); io_write(IXP, 8'h87);
    io_read(IXP, v); check("R2 broken key index read", v, 8'hFF);
    io_write(IXP, 8'h87);
    io_read(IXP, v); check("R2 open index read", v, 8'h00);
    io_write(IXP, 8'hAA);
    io_write(IXP, 8'h87); io_write(DTP, 8'h00); io_write(IXP, 8'h87);
    io_read(IXP, v); check("R2 data write between keys", v, 8'hFF);
    io_write(IXP, 8'hAA);
  endtask

  task automatic t_ldn_fields();
    logic [7:0] v;
    unlock();
    wreg(8'h07, 8'h03);
    rreg(8'h07, v); check("R4 ldn readback", v, 8'h03);
    wreg(8'hF6, 8'h20);
    rreg(8'hF6, v); check("R4 other device read", v, 8'hFF);
    wreg(8'h07, 8'h07);
    rreg(8'hF6, v); check("R4 other device write ignored", v, 8'h01);
    rreg(8'hF1, v); check("R5 unimplemented index", v, 8'hFF);
    wreg(8'hF0, 8'h7F);
    rreg(8'hF0, v); check("R5 F0 low bits", v, 8'h00);
    wreg(8'hF0, 8'h80);
    rreg(8'hF0, v); check("R5 F0 bit7", v, 8'h80);
    wreg(8'hF6, 8'h05);
    rreg(8'hF6, v); check("R5 F6 value", v, 8'h05);
    wreg(8'hF6, 8'h00);
    rreg(8'hF6, v); check("R6 zero count ignored", v, 8'h05);
  endtask

  task automatic t_timeout();
    logic [7:0] v;
    wreg(8'hF6, 8'h03);
    wreg(8'hF5, 8'h20);
    wait_cyc(29); check("R7 before expiry", {7'b0, wdt_rst_n}, 8'h01);
    wait_cyc(1);  check("R9 pulse start", {7'b0, wdt_rst_n}, 8'h00);
    wait_cyc(PW - 1); check("R9 pulse last", {7'b0, wdt_rst_n}, 8'h00);
    wait_cyc(1);  check("R9 pulse end", {7'b0, wdt_rst_n}, 8'h01);
    rreg(8'hF5, v); check("R9 flag set", v, 8'h60);
    wreg(8'hF5, 8'h00);
    rreg(8'hF5, v); check("R11 write zero keeps flag", v, 8'h40);
    wreg(8'hF5, 8'h40);
    rreg(8'hF5, v); check("R11 w1c clears flag", v, 8'h00);
  endtask

  task automatic t_kick();
    wreg(8'hF6, 8'h03);
    wreg(8'hF5, 8'h20);
    wait_cyc(20);
    wreg(8'hF5, 8'h20);
    wait_cyc(29); check("R7 kick restarts", {7'b0, wdt_rst_n}, 8'h01);
    wait_cyc(1);  check("R7 kick expiry", {7'b0, wdt_rst_n}, 8'h00);
    wait_cyc(PW);
    wreg(8'hF5, 8'h60);
    wait_cyc(15);
    wreg(8'hF6, 8'h05);
    wait_cyc(49); check("R8 count rewrite restarts", {7'b0, wdt_rst_n}, 8'h01);
    wait_cyc(1);  check("R8 new count expiry", {7'b0, wdt_rst_n}, 8'h00);
    wait_cyc(PW);
    wreg(8'hF5, 8'h40);
  endtask

  task automatic t_silent();
    logic [7:0] v;
    int lows = 0;
    wreg(8'hF0, 8'h00);
    wreg(8'hF6, 8'h02);
    wreg(8'hF5, 8'h20);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); if (!wdt_rst_n) lows++;
    end
    check("R10 no pulse when disabled", 8'(lows), 8'h00);
    rreg(8'hF5, v); check("R10 flag only", v, 8'h60);
    wreg(8'hF0, 8'h80);
    lows = 0;
    for (int i = 0; i < 2700; i++) begin
      @(negedge clk); if (!wdt_rst_n) lows++;
    end
    check("R10 counter stays at zero", 8'(lows), 8'h00);
    wreg(8'hF5, 8'h40);
  endtask

  task automatic t_disable();
    logic [7:0] v;
    int lows = 0;
    wreg(8'hF6, 8'h02);
    wreg(8'hF5, 8'h20);
    wait_cyc(5);
    wreg(8'hF5, 8'h00);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); if (!wdt_rst_n) lows++;
    end
    check("R12 disable halts", 8'(lows), 8'h00);
    rreg(8'hF5, v); check("R12 flag stays clear", v, 8'h00);
  endtask

  task automatic t_exit();
    logic [7:0] v;
    io_write(IXP, 8'hAA);
    io_read(IXP, v); check("R3 index read after exit", v, 8'hFF);
    io_write(IXP, 8'hF6); io_write(DTP, 8'h77);
    io_read(DTP, v); check("R3 data read after exit", v, 8'hFF);
    unlock();
    rreg(8'hF6, v); check("R3 write after exit ignored", v, 8'h02);
  endtask

  initial begin
    fork
      begin
        wait_cyc(3); rst_n = 1'b1; wait_cyc(2);
        t_reset(); t_unlock(); t_ldn_fields(); t_timeout();
        t_kick(); t_silent(); t_disable(); t_exit();
      end
      begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule